// File: doc/BRIEF.md
# Hitless Time-Slot Interchange Switch

This block is a byte-wide time and space switch for frame-aligned SONET-style streams. Each of the `N_IN` input streams carries `SLOTS` (12) byte-interleaved STS-1 time slots per row. Every output byte slot can take its content from any input stream and any slot position, and one input slot can feed many output slots at once, up to a full broadcast. Because any output can pick any slot of any input, STS-3c and STS-12c payloads are switched by writing matching entries for all of their constituent slots. An STS-3c group `g` uses slots `g`, `g+4` and `g+8`.

Each input row is stored in one half of a ping-pong slot buffer while the other half, which holds the previous row, is read out through the connection map. Software writes a shadow map through a small register port and reads back the active map there. A commit request makes the shadow map active at the next frame start, so every output row is built from one map and a change causes no hits. Any output slot can be forced to AIS (all ones) or unequipped (all zeros) content instead of switched data.

Top module: `tsi_switch`

## Requirements
- R1: While `rst_n` is low, and after it, the active and shadow maps are the identity map: entry `o*SLOTS+p` selects input `o`, slot `p`, code pass. `commit_pending`, `out_sof` and `out_data` are 0.
- R2: Rows are counted from `in_sof`, which marks slot 0 of the first row of a frame. The byte that output `o` presents one cycle after input slot `q` of row `k+1` is the byte that input `src` carried in slot `sl` of row `k`, where `src` and `sl` come from map entry `o*SLOTS+q`.
- R3: Many output slots, on the same or on different outputs, can select one input slot at the same time, up to every slot of every output.
- R4: Writes from `cfg_we` go to the shadow map only. They leave the switched data and `cfg_rdata` unchanged until a commit takes effect.
- R5: A commit makes the shadow map active at the first `in_sof` after the cycle in which `commit_req` was high. A request in an `in_sof` cycle waits for the next `in_sof`. `commit_pending` is high from the cycle after the request until the swap edge.
- R6: Code 01 in an entry drives all ones into that output slot (AIS). Code 10 drives all zeros (unequipped). Codes 00 and 11 pass the selected byte.
- R7: For an STS-3c group, the output slots `g`, `g+4`, `g+8` that map to the source slots `h`, `h+4`, `h+8` of one input carry those bytes in the same order.
- R8: An output whose twelve slots map one to one onto the twelve slots of one input carries that whole STS-12c row in its original order.
- R9: `out_sof` is high exactly one cycle after `in_sof`. The output frame switches over to a newly committed map at that row.
- R10: Entry layout: bits [1:0] hold the code, bits [SW+1:2] the source slot and the bits above them the source input, where SW = clog2(SLOTS). Address `o*SLOTS+p` selects output `o`, slot `p`. `cfg_rdata` shows the active entry at `cfg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sof | input | 1 | Start of frame on the inputs (slot 0 of row 0) |
| in_data | input | N_IN*8 | One byte per input stream, stream i in bits [8i+7:8i] |
| out_sof | output | 1 | Start of frame on the outputs |
| out_data | output | N_IN*8 | One switched byte per output stream |
| cfg_we | input | 1 | Write the shadow map entry at cfg_addr |
| cfg_addr | input | clog2(N_IN*SLOTS) | Map entry address, output*SLOTS+slot |
| cfg_wdata | input | EW | Entry to write (code, source slot, source input) |
| cfg_rdata | output | EW | Active map entry at cfg_addr |
| commit_req | input | 1 | Request that the shadow map become active |
| commit_pending | output | 1 | A commit waits for the next frame start |

## Verification
The bench builds the default configuration: four streams of twelve slots, with frames of three rows that it generates itself. Four streams are enough for a cross-stream reversal, a broadcast from one slot into all 48 outputs, an STS-3c group moved between streams and group positions, and a full STS-12c remap, all checked byte by byte. Three-row frames put several swap points into a short run, so one run covers commits made in mid-frame, in the same cycle as a frame start, and together with shadow writes.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   typedef enum logic [1:0] {
      SUB_PASS  = 2'b00,
      SUB_AIS   = 2'b01,
      SUB_UNEQ  = 2'b10,
      SUB_PASS3 = 2'b11
   } sub_e;

   localparam int unsigned CODE_W = 2;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
   parameter int unsigned SLOTS = 12,
   localparam int unsigned SW   = tsi_pkg::idx_w(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sof,
   output logic [SW-1:0] cur_slot,
   output logic          wr_bank
);
   logic [SW-1:0] slot_q;
   logic          bank_q;
   logic          row_end;

   assign cur_slot = sof ? '0 : slot_q;
   assign row_end  = (cur_slot == SW'(SLOTS - 1));
   assign wr_bank  = bank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         bank_q <= 1'b0;
      end else begin
         slot_q <= row_end ? '0 : cur_slot + SW'(1);
         if (row_end) bank_q <= ~bank_q;
      end
   end

   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(slot_q) < SLOTS); // R2
endmodule

// File: rtl/tsi_slot_buffer.sv
module tsi_slot_buffer #(
   parameter int unsigned N_IN  = 4,
   parameter int unsigned SLOTS = 12,
   parameter int unsigned DW    = 8,
   localparam int unsigned SW   = tsi_pkg::idx_w(SLOTS),
   localparam int unsigned IW   = tsi_pkg::idx_w(N_IN)
) (
   input  logic               clk,
   input  logic               wr_bank,
   input  logic [SW-1:0]      wr_slot,
   input  logic [N_IN*DW-1:0] wr_data,
   input  logic [N_IN*IW-1:0] rd_src,
   input  logic [N_IN*SW-1:0] rd_slot,
   output logic [N_IN*DW-1:0] rd_data
);
   logic [DW-1:0] mem [2][N_IN][SLOTS];
   logic          rd_bank;

   assign rd_bank = ~wr_bank;

   always_ff @(posedge clk) begin
      for (int i = 0; i < N_IN; i++)
         mem[wr_bank][i][wr_slot] <= wr_data[i*DW +: DW];
   end

   always_comb begin
      for (int o = 0; o < N_IN; o++) begin
         int s;
         int q;
         s = int'(rd_src[o*IW +: IW]);
         q = int'(rd_slot[o*SW +: SW]);
         if (s < N_IN && q < SLOTS) rd_data[o*DW +: DW] = mem[rd_bank][s][q];
         else                       rd_data[o*DW +: DW] = '0;
      end
   end
endmodule

// File: rtl/tsi_conn_map.sv
module tsi_conn_map #(
   parameter int unsigned N_IN  = 4,
   parameter int unsigned SLOTS = 12,
   localparam int unsigned SW   = tsi_pkg::idx_w(SLOTS),
   localparam int unsigned IW   = tsi_pkg::idx_w(N_IN),
   localparam int unsigned EW   = IW + SW + tsi_pkg::CODE_W,
   localparam int unsigned NE   = N_IN * SLOTS,
   localparam int unsigned AW   = tsi_pkg::idx_w(NE)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sof,
   input  logic [SW-1:0]      rd_slot,
   input  logic               cfg_we,
   input  logic [AW-1:0]      cfg_addr,
   input  logic [EW-1:0]      cfg_wdata,
   input  logic               commit_req,
   output logic [EW-1:0]      cfg_rdata,
   output logic [N_IN*EW-1:0] lookup,
   output logic               pending
);
   logic [EW-1:0]    shadow [NE];
   logic [EW-1:0]    active [NE];
   logic [NE*EW-1:0] act_flat;
   logic             pend_q;
   logic             swap;

   assign swap    = sof & pend_q;
   assign pending = pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NE; k++) begin
            shadow[k] <= {IW'(k / SLOTS), SW'(k % SLOTS), 2'b00};
            active[k] <= {IW'(k / SLOTS), SW'(k % SLOTS), 2'b00};
         end
         pend_q <= 1'b0;
      end else begin
         if (swap)
            for (int k = 0; k < NE; k++) active[k] <= shadow[k];
         if (cfg_we && int'(cfg_addr) < NE) shadow[cfg_addr] <= cfg_wdata;
         pend_q <= commit_req | (pend_q & ~sof);
      end
   end

   always_comb begin
      cfg_rdata = (int'(cfg_addr) < NE) ? active[cfg_addr] : '0;
      for (int k = 0; k < NE; k++) act_flat[k*EW +: EW] = active[k];
      for (int o = 0; o < N_IN; o++) begin
         int idx;
         idx = o * SLOTS + int'(rd_slot);
         lookup[o*EW +: EW] = swap ? shadow[idx] : active[idx];
      end
   end

   AST_ACTIVE_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_flat) |-> $past(sof)); // R5
   AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !sof) |=> pend_q); // R5
   AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && sof && !commit_req) |=> !pend_q); // R5
   AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |=> pend_q); // R5
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
   parameter int unsigned N_IN  = 4,
   parameter int unsigned SLOTS = 12,
   parameter int unsigned DW    = 8,
   localparam int unsigned SW   = tsi_pkg::idx_w(SLOTS),
   localparam int unsigned IW   = tsi_pkg::idx_w(N_IN),
   localparam int unsigned EW   = IW + SW + tsi_pkg::CODE_W,
   localparam int unsigned AW   = tsi_pkg::idx_w(N_IN * SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_sof,
   input  logic [N_IN*DW-1:0] in_data,
   output logic               out_sof,
   output logic [N_IN*DW-1:0] out_data,
   input  logic               cfg_we,
   input  logic [AW-1:0]      cfg_addr,
   input  logic [EW-1:0]      cfg_wdata,
   output logic [EW-1:0]      cfg_rdata,
   input  logic               commit_req,
   output logic               commit_pending
);
   import tsi_pkg::*;

   if (N_IN < 1)  begin : g_bad_n  $error("N_IN must be at least 1");  end
   if (SLOTS < 2) begin : g_bad_s  $error("SLOTS must be at least 2"); end
   if (DW < 1)    begin : g_bad_dw $error("DW must be at least 1");    end

   logic [SW-1:0]      cur_slot;
   logic               wr_bank;
   logic [N_IN*EW-1:0] lookup;
   logic [N_IN*IW-1:0] rd_src;
   logic [N_IN*SW-1:0] rd_slot;
   logic [N_IN*DW-1:0] rd_data;

   tsi_frame_timer #(.SLOTS(SLOTS)) u_timer (
      .clk(clk), .rst_n(rst_n), .sof(in_sof),
      .cur_slot(cur_slot), .wr_bank(wr_bank));

   tsi_conn_map #(.N_IN(N_IN), .SLOTS(SLOTS)) u_map (
      .clk(clk), .rst_n(rst_n), .sof(in_sof), .rd_slot(cur_slot),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .commit_req(commit_req), .cfg_rdata(cfg_rdata),
      .lookup(lookup), .pending(commit_pending));

   tsi_slot_buffer #(.N_IN(N_IN), .SLOTS(SLOTS), .DW(DW)) u_buf (
      .clk(clk), .wr_bank(wr_bank), .wr_slot(cur_slot), .wr_data(in_data),
      .rd_src(rd_src), .rd_slot(rd_slot), .rd_data(rd_data));

   always_ff @(posedge clk) begin
      if (!rst_n) out_sof <= 1'b0;
      else        out_sof <= in_sof;
   end

   for (genvar o = 0; o < N_IN; o++) begin : g_out
      logic [EW-1:0] ent;
      sub_e          code;
      logic [DW-1:0] nxt;

      assign ent = lookup[o*EW +: EW];
      assign code = sub_e'(ent[CODE_W-1:0]);
      assign rd_slot[o*SW +: SW] = ent[CODE_W +: SW];
      assign rd_src[o*IW +: IW]  = ent[CODE_W+SW +: IW];

      always_comb begin
         case (code)
            SUB_AIS:  nxt = '1;
            SUB_UNEQ: nxt = '0;
            default:  nxt = rd_data[o*DW +: DW];
         endcase
      end

      always_ff @(posedge clk) begin
         if (!rst_n) out_data[o*DW +: DW] <= '0;
         else        out_data[o*DW +: DW] <= nxt;
      end

      AST_AIS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
         (code == SUB_AIS) |=> (out_data[o*DW +: DW] == '1)); // R6
      AST_UNEQ_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
         (code == SUB_UNEQ) |=> (out_data[o*DW +: DW] == '0)); // R6
   end
endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
   localparam int N   = 4;
   localparam int SL  = 12;
   localparam int FL  = SL * 3;
   localparam int EW  = 8;
   localparam int AW  = 6;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           in_sof;
   logic [N*8-1:0] in_data;
   logic           out_sof;
   logic [N*8-1:0] out_data;
   logic           cfg_we;
   logic [AW-1:0]  cfg_addr;
   logic [EW-1:0]  cfg_wdata;
   logic [EW-1:0]  cfg_rdata;
   logic           commit_req;
   logic           commit_pending;

   always #2 clk = ~clk;

   tsi_switch #(.N_IN(N), .SLOTS(SL), .DW(8)) uut (
      .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_data(in_data),
      .out_sof(out_sof), .out_data(out_data), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .commit_req(commit_req), .commit_pending(commit_pending));

   int    checks = 0;
   int    errors = 0;
   int    c = 0;
   string tag = "R2";

   int m_sh [N*SL];
   int m_act[N*SL];
   int m_pend;
   int hist [64][N];

   function automatic int ent(int src, int sl, int code);
      return (src << 6) | (sl << 2) | code;
   endfunction

   function automatic int pat(int cyc, int i);
      return (cyc * 29 + i * 71 + 13) & 255;
   endfunction

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, c, act, exp);
      end
   endtask

   task automatic tick();
      int slot;
      int sof;
      int exp[N];
      int codes[N];
      slot = c % SL;
      sof  = (c % FL == 0) ? 1 : 0;
      in_sof = sof[0];
      for (int i = 0; i < N; i++) in_data[i*8 +: 8] = 8'(pat(c, i));
      @(posedge clk);
      for (int o = 0; o < N; o++) begin
         int e;
         e = (sof == 1 && m_pend == 1) ? m_sh[o*SL+slot] : m_act[o*SL+slot];
         codes[o] = e & 3;
         if ((e & 3) == 1)      exp[o] = 255;
         else if ((e & 3) == 2) exp[o] = 0;
         else                   exp[o] = hist[(c - slot - SL + ((e >> 2) & 15)) % 64][e >> 6];
      end
      for (int i = 0; i < N; i++) hist[c % 64][i] = pat(c, i);
      if (sof == 1 && m_pend == 1)
         for (int k = 0; k < N*SL; k++) m_act[k] = m_sh[k];
      if (cfg_we) m_sh[cfg_addr] = int'(cfg_wdata);
      m_pend = (commit_req || (m_pend == 1 && sof == 0)) ? 1 : 0;
      #1;
      chk("R9", int'(out_sof), sof, "out_sof");
      chk("R5", int'(commit_pending), m_pend, "commit_pending");
      chk("R10", int'(cfg_rdata), m_act[cfg_addr], "cfg_rdata");
      if (c >= 2*SL)
         for (int o = 0; o < N; o++)
            chk((codes[o] == 1 || codes[o] == 2) ? "R6" : tag,
                int'(out_data[o*8 +: 8]), exp[o], "out_data");
      @(negedge clk);
      cfg_we = 1'b0;
      commit_req = 1'b0;
      c++;
   endtask

   task automatic run(int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic wr(int o, int p, int src, int sl, int code);
      cfg_we = 1'b1;
      cfg_addr = AW'(o*SL + p);
      cfg_wdata = EW'(ent(src, sl, code));
      tick();
   endtask

   task automatic commit_now();
      commit_req = 1'b1;
      tick();
   endtask

   initial begin
      #(4*200000);
      errors++;
      $display("FAIL watchdog expired at cycle %0d", c);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_sof = 1'b0; in_data = '0; cfg_we = 1'b0;
      cfg_addr = '0; cfg_wdata = '0; commit_req = 1'b0; m_pend = 0;
      for (int k = 0; k < N*SL; k++) begin
         m_sh[k]  = ent(k / SL, k % SL, 0);
         m_act[k] = m_sh[k];
      end
      for (int r = 0; r < 64; r++)
         for (int i = 0; i < N; i++) hist[r][i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state and identity readback
      chk("R1", int'(out_data), 0, "out_data in reset");
      chk("R1", int'(out_sof), 0, "out_sof in reset");
      chk("R1", int'(commit_pending), 0, "pending in reset");
      for (int k = 0; k < N*SL; k++) begin
         cfg_addr = AW'(k);
         #1;
         chk("R1", int'(cfg_rdata), ent(k / SL, k % SL, 0), "identity map");
      end
      cfg_addr = '0;
      @(negedge clk);
      rst_n = 1'b1;

      // R2: identity switching over two frames
      tag = "R2";
      run(2*FL);

      // R4: shadow writes, cross-stream reversal, not yet visible
      tag = "R4";
      for (int p = 0; p < SL; p++) wr(0, p, 3, SL-1-p, 0);
      for (int p = 0; p < SL; p++) wr(3, p, 1, p, 0);
      run(FL - (c % FL) + 3);
      // R5: mid-frame commit, swap at the next frame start
      tag = "R5";
      commit_now();
      run(2*FL);

      // R5: commit in the cycle of a frame start waits one more frame
      tag = "R5";
      for (int p = 0; p < SL; p++) wr(1, p, 2, (p + 5) % SL, 0);
      run(FL - (c % FL));
      commit_now();
      run(2*FL);

      // R3: full broadcast of input 1 slot 5
      tag = "R3";
      for (int k = 0; k < N*SL; k++) wr(k / SL, k % SL, 1, 5, 0);
      commit_now();
      run(2*FL);

      // R6: AIS, unequipped and pass codes side by side
      tag = "R6";
      for (int p = 0; p < SL; p++) wr(2, p, 0, p, p % 4);
      commit_now();
      run(2*FL);

      // R7: STS-3c group 1 of output 1 from group 3 of input 2
      // R8: STS-12c of input 0 onto output 3; rest identity
      tag = "R7";
      for (int k = 0; k < N*SL; k++) wr(k / SL, k % SL, k / SL, k % SL, 0);
      for (int j = 0; j < 3; j++) wr(1, 1 + 4*j, 2, 3 + 4*j, 0);
      for (int p = 0; p < SL; p++) wr(3, p, 0, p, 0);
      commit_now();
      run(FL);
      tag = "R8";
      run(2*FL);

      // R10: readback of every active entry
      tag = "R10";
      for (int k = 0; k < N*SL; k++) begin
         cfg_addr = AW'(k);
         tick();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule